// File: doc/BRIEF.md
# Frequency-Trimmed Reference Time Counter

This block keeps a 64-bit time count that advances by one unit on every clock. A 24-bit phase accumulator trims its rate. Software sets a signed correction word, and the accumulator adds that magnitude on every counting clock. Each carry out of the accumulator produces one tick, which is either an extra step forward or a skipped step. The correction magnitude is computed from a parts-per-billion offset as offset × 2^24 / 10^9. Software does that conversion before it writes the register.

A small word-addressed register bus gives access to the block. The count is read as two 32-bit halves. Reading the low half freezes the high half in a shadow, so a pair of reads always forms one consistent value. To place a new value, software halts the counter, writes both halves and then releases it. Loads that arrive while the counter runs are dropped.

Top module: `rtc_trimmed_counter`

## Requirements
- R1: After reset the count is 0 and the counter is running. The correction word (byte offset 0x0C) reads 0, which means correction is off.
- R2: With the correction enable bit (offset 0x0C, bit 31) clear, the count grows by exactly 1 per clock while running.
- R3: With enable set and the direction bit (bit 30) clear, the magnitude M in bits 23:0 is added to a 24-bit accumulator on each running clock. On a carry the accumulator returns to zero and the count grows by 2 in that clock instead of 1. Carries therefore fall every ceil(2^24/M) running clocks, counted from the last correction write.
- R4: With enable set and the direction bit set, the count holds (step 0) in each carry clock instead of growing by 1.
- R5: Any write to offset 0x0C clears the accumulator. An all-zero word turns correction off. An enabled word with magnitude 0 gives the nominal rate, and so does a disabled word with a non-zero magnitude.
- R6: A magnitude above 0x400000 (the 250,000,000 ppb limit) is stored as 0x400000. A read of 0x0C returns enable in bit 31, direction in bit 30, zeros in bits 29:24 and the stored magnitude in bits 23:0.
- R7: Writing offset 0x00 with bit 0 set halts the counter. Neither the count nor the accumulator advances while halted. When bits 0 and 1 are both set in one write, the halt wins.
- R8: While halted, writes to 0x04 and 0x08 replace the low and high 32 bits of the count. Writing 0x00 with bit 1 set (bit 0 clear) releases the counter. The first step comes one clock after the release write.
- R9: Writes to 0x04 or 0x08 while the counter runs have no effect on the count.
- R10: A read of 0x04 returns the current low word and latches the high word into a shadow. A read of 0x08 returns that shadow, even if the live high word has since moved on.
- R11: The count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the clock of bus_rd (0 otherwise) |

## Verification
Wrong state in the accumulator does not show at once. It appears at the ports as a carry pattern shifted in phase, so the count drifts from the expected value by a whole tick only after up to ceil(2^24/M) clocks. The bench therefore measures over spans of several carry periods and predicts the exact number of carries from the write and halt instants. Wrong run, load or shadow state shows on the very next read of the count, because each read pair is compared against a value predicted from the clock number of the sample.

// File: rtl/rtc_pkg.sv
// Shared definitions for the trimmed time counter: register word index
// and control bit positions that the bus decoder and the bench agree on.
package rtc_pkg;

    // Word index taken from byte address bits 3:2.
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LO   = 2'd1,
        REG_HI   = 2'd2,
        REG_TRIM = 2'd3
    } reg_idx_t;

    // Control word bits.
    localparam int unsigned CTRL_HALT_BIT    = 0;
    localparam int unsigned CTRL_RELEASE_BIT = 1;

    // Correction word flag bits (top of a 32-bit word).
    localparam int unsigned TRIM_EN_BIT  = 31;
    localparam int unsigned TRIM_NEG_BIT = 30;

endpackage

// File: rtl/rtc_regfile.sv
// Register bus front end.
// Decodes single-clock read and write strobes into control pulses,
// keeps the correction word (magnitude saturated on write) and the
// high-word shadow that a low-word read captures.
// Assumes: BUS_W >= ACC_W + 2; one access per clock.
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int unsigned BUS_W   = 32,
    parameter int unsigned ACC_W   = 24,
    parameter int unsigned MAG_MAX = 32'h0040_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [3:0]         addr_i,
    input  logic [BUS_W-1:0]   wdata_i,
    output logic [BUS_W-1:0]   rdata_o,
    input  logic [2*BUS_W-1:0] count_i,
    output logic               halt_o,
    output logic               release_o,
    output logic [1:0]         ld_we_o,
    output logic [BUS_W-1:0]   ld_data_o,
    output logic               trim_wr_o,
    output logic               trim_en_o,
    output logic               trim_neg_o,
    output logic [ACC_W-1:0]   trim_mag_o,
    output logic               rd_lo_o,
    output logic [BUS_W-1:0]   shadow_o
);

    localparam int unsigned   PAD_W   = BUS_W - 2 - ACC_W;
    localparam logic [ACC_W-1:0] MAG_LIM = ACC_W'(MAG_MAX);

    reg_idx_t         idx;
    logic [ACC_W-1:0] mag_req;
    logic [ACC_W-1:0] mag_sat;
    logic             en_q;
    logic             neg_q;
    logic [ACC_W-1:0] mag_q;
    logic [BUS_W-1:0] shadow_q;
    logic             unused_addr;

    assign idx         = reg_idx_t'(addr_i[3:2]);
    assign unused_addr = ^addr_i[1:0];
    assign ld_data_o   = wdata_i;

    // Purpose: saturate the requested magnitude to the rate limit.
    always_comb begin
        mag_req = wdata_i[ACC_W-1:0];
        mag_sat = (mag_req > MAG_LIM) ? MAG_LIM : mag_req;
    end

    // Purpose: turn a write strobe into per-register pulses.
    always_comb begin
        halt_o    = 1'b0;
        release_o = 1'b0;
        ld_we_o   = 2'b00;
        trim_wr_o = 1'b0;
        if (wr_i) begin
            case (idx)
                REG_CTRL: begin
                    halt_o    = wdata_i[CTRL_HALT_BIT];
                    release_o = wdata_i[CTRL_RELEASE_BIT] & ~wdata_i[CTRL_HALT_BIT];
                end
                REG_LO:   ld_we_o[0] = 1'b1;
                REG_HI:   ld_we_o[1] = 1'b1;
                REG_TRIM: trim_wr_o  = 1'b1;
                default:  ;
            endcase
        end
    end

    // Purpose: flag a low-word read so the shadow captures the high word.
    assign rd_lo_o = rd_i && (idx == REG_LO);

    // Purpose: hold the correction word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            neg_q <= 1'b0;
            mag_q <= '0;
        end else if (trim_wr_o) begin
            en_q  <= wdata_i[TRIM_EN_BIT];
            neg_q <= wdata_i[TRIM_NEG_BIT];
            mag_q <= mag_sat;
        end
    end

    // Purpose: capture the high word at the clock of a low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (rd_lo_o) begin
            shadow_q <= count_i[2*BUS_W-1:BUS_W];
        end
    end

    // Purpose: read data multiplexer, zero outside a read.
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (idx)
                REG_LO:   rdata_o = count_i[BUS_W-1:0];
                REG_HI:   rdata_o = shadow_q;
                REG_TRIM: rdata_o = {en_q, neg_q, {PAD_W{1'b0}}, mag_q};
                default:  rdata_o = '0;
            endcase
        end
    end

    assign trim_en_o  = en_q;
    assign trim_neg_o = neg_q;
    assign trim_mag_o = mag_q;
    assign shadow_o   = shadow_q;

endmodule

// File: rtl/rtc_trim_accum.sv
// Phase accumulator for rate trimming.
// On each running clock with trimming enabled it adds the magnitude.
// A carry out raises slip_o for that clock and returns the
// accumulator to zero. A correction write clears it and suppresses
// the slip in the same clock.
// Assumes: mag_i is already saturated by the register front end.
module rtc_trim_accum #(
    parameter int unsigned ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [ACC_W-1:0] mag_i,
    output logic             slip_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             carry;

    // Purpose: next phase and carry out.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, mag_i};
        carry = sum[ACC_W];
    end

    assign slip_o = run_i & en_i & ~clr_i & carry;

    // Purpose: advance, wrap to zero on carry, or clear on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr_i) begin
            acc_q <= '0;
        end else if (run_i && en_i) begin
            acc_q <= carry ? '0 : sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/rtc_time_core.sv
// Time count register and run flag.
// While running, the count steps by 1, or by 2 / 0 in a slip clock
// depending on direction. While halted it holds and accepts word loads.
// Halt and release take effect from the next clock.
// Assumes: COUNT_W is a whole multiple of BUS_W.
module rtc_time_core #(
    parameter int unsigned COUNT_W = 64,
    parameter int unsigned BUS_W   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        halt_i,
    input  logic                        release_i,
    input  logic [COUNT_W/BUS_W-1:0]    ld_we_i,
    input  logic [BUS_W-1:0]            ld_data_i,
    input  logic                        slip_i,
    input  logic                        neg_i,
    output logic [COUNT_W-1:0]          count_o,
    output logic                        run_o
);

    localparam int unsigned NUM_W = COUNT_W / BUS_W;

    logic [COUNT_W-1:0] cnt_q;
    logic [COUNT_W-1:0] step;
    logic               run_q;

    // Purpose: choose the step size for this clock.
    always_comb begin
        if (slip_i) begin
            step = neg_i ? '0 : COUNT_W'(2);
        end else begin
            step = COUNT_W'(1);
        end
    end

    // Purpose: run flag, halt has priority over release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b1;
        end else if (halt_i) begin
            run_q <= 1'b0;
        end else if (release_i) begin
            run_q <= 1'b1;
        end
    end

    // Purpose: count while running, accept word loads while halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= cnt_q + step;
        end else begin
            for (int w = 0; w < NUM_W; w++) begin
                if (ld_we_i[w]) begin
                    cnt_q[w*BUS_W +: BUS_W] <= ld_data_i;
                end
            end
        end
    end

    assign count_o = cnt_q;
    assign run_o   = run_q;

endmodule

// File: rtl/rtc_trimmed_counter.sv
// Top of the trimmed time counter: register front end, phase
// accumulator and count core.
// Assumes: COUNT_W = 2 * bus width; one bus access per clock.
module rtc_trimmed_counter #(
    parameter int unsigned COUNT_W = 64,
    parameter int unsigned ACC_W   = 24,
    parameter int unsigned MAG_MAX = 32'h0040_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [3:0]             bus_addr,
    input  logic [COUNT_W/2-1:0]   bus_wdata,
    output logic [COUNT_W/2-1:0]   bus_rdata
);

    localparam int unsigned BUS_W = COUNT_W / 2;

    logic               halt_w;
    logic               release_w;
    logic [1:0]         ld_we_w;
    logic [BUS_W-1:0]   ld_data_w;
    logic               trim_wr_w;
    logic               trim_en_w;
    logic               trim_neg_w;
    logic [ACC_W-1:0]   trim_mag_w;
    logic               rd_lo_w;
    logic [BUS_W-1:0]   shadow_w;
    logic [COUNT_W-1:0] count_w;
    logic               run_w;
    logic               slip_w;

    rtc_regfile #(
        .BUS_W   (BUS_W),
        .ACC_W   (ACC_W),
        .MAG_MAX (MAG_MAX)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .rd_i       (bus_rd),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .count_i    (count_w),
        .halt_o     (halt_w),
        .release_o  (release_w),
        .ld_we_o    (ld_we_w),
        .ld_data_o  (ld_data_w),
        .trim_wr_o  (trim_wr_w),
        .trim_en_o  (trim_en_w),
        .trim_neg_o (trim_neg_w),
        .trim_mag_o (trim_mag_w),
        .rd_lo_o    (rd_lo_w),
        .shadow_o   (shadow_w)
    );

    rtc_trim_accum #(
        .ACC_W (ACC_W)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_w),
        .en_i   (trim_en_w),
        .clr_i  (trim_wr_w),
        .mag_i  (trim_mag_w),
        .slip_o (slip_w)
    );

    rtc_time_core #(
        .COUNT_W (COUNT_W),
        .BUS_W   (BUS_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (halt_w),
        .release_i (release_w),
        .ld_we_i   (ld_we_w),
        .ld_data_i (ld_data_w),
        .slip_i    (slip_w),
        .neg_i     (trim_neg_w),
        .count_o   (count_w),
        .run_o     (run_w)
    );

endmodule

// File: rtl/rtc_trimmed_counter_chk.sv
// Property checker for the trimmed time counter, bound to the top.
// Assumes: synchronous active-low reset held for at least one clock.
module rtc_trimmed_counter_chk #(
    parameter int unsigned COUNT_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run,
    input logic               slip,
    input logic               trim_en,
    input logic               trim_neg,
    input logic               ld_any,
    input logic               rd_lo,
    input logic [COUNT_W/2-1:0] shadow,
    input logic [COUNT_W-1:0] cnt
);

    logic rst_seen = 1'b0;
    logic armed    = 1'b0;

    // Purpose: arm the properties one clock after reset has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_seen <= 1'b1;
            armed    <= 1'b0;
        end else begin
            armed    <= rst_seen;
        end
    end

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(run) && !$past(slip)) |-> (cnt == $past(cnt) + COUNT_W'(1)));

    p_slip_up_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(run) && $past(slip) && !$past(trim_neg)) |-> (cnt == $past(cnt) + COUNT_W'(2)));

    p_slip_down_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(run) && $past(slip) && $past(trim_neg)) |-> (cnt == $past(cnt)));

    p_no_slip_off_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !trim_en |-> !slip);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!$past(run) && !$past(ld_any)) |-> (cnt == $past(cnt)));

    p_shadow_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(rd_lo) |-> (shadow == $past(shadow)));

endmodule

bind rtc_trimmed_counter rtc_trimmed_counter_chk #(
    .COUNT_W (COUNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .slip     (slip_w),
    .trim_en  (trim_en_w),
    .trim_neg (trim_neg_w),
    .ld_any   (|ld_we_w),
    .rd_lo    (rd_lo_w),
    .shadow   (shadow_w),
    .cnt      (count_w)
);

// File: tb/rtc_trimmed_counter_tb.sv
// Directed bench for the trimmed time counter.
module rtc_trimmed_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int unsigned cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_trimmed_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Single-clock write; e returns the clock edge that takes it.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int unsigned e);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        e = cyc + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdw(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // Coherent 64-bit read; p is the number of edges already applied.
    task automatic snap(output logic [63:0] v, output int unsigned p);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'h4;
        #1 v[31:0] = bus_rdata;
        p = cyc;
        @(negedge clk);
        bus_addr = 4'h8;
        #1 v[63:32] = bus_rdata;
        bus_rd = 1'b0;
    endtask

    function automatic int unsigned period(input int unsigned m);
        int unsigned me;
        me = (m > 32'h40_0000) ? 32'h40_0000 : m;
        return (32'h100_0000 + me - 1) / me;
    endfunction

    task automatic t_reset();
        logic [63:0] v; logic [31:0] d; int unsigned p, rel;
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rel = cyc;
        snap(v, p);
        chk("R1 count from reset", v, 64'(p - rel));
        rdw(4'hC, d);
        chk("R1 correction off", 64'(d), 64'h0);
    endtask

    task automatic t_nominal();
        logic [63:0] a, b; int unsigned pa, pb;
        snap(a, pa);
        repeat (9) @(negedge clk);
        snap(b, pb);
        chk("R2 nominal rate", b - a, 64'(pb - pa));
    endtask

    task automatic t_zero_cfg();
        logic [63:0] a, b; logic [31:0] d; int unsigned pa, pb, w;
        wr(4'hC, 32'h8000_0000, w);
        snap(a, pa); repeat (12) @(negedge clk); snap(b, pb);
        chk("R5 enabled zero magnitude", b - a, 64'(pb - pa));
        wr(4'hC, 32'h0040_0000, w);
        rdw(4'hC, d);
        chk("R6 readback disabled word", 64'(d), 64'h0040_0000);
        snap(a, pa); repeat (12) @(negedge clk); snap(b, pb);
        chk("R5 disabled with magnitude", b - a, 64'(pb - pa));
        wr(4'hC, 32'h0, w);
    endtask

    task automatic t_trim(input logic [23:0] m, input bit neg, input string req);
        logic [63:0] a, b, exp; logic [31:0] d; int unsigned pa, pb, w, per, ex;
        wr(4'hC, {1'b1, neg, 6'b0, m}, w);
        per = period(32'(m));
        if (m > 24'h40_0000) begin
            rdw(4'hC, d);
            chk("R6 saturated readback", 64'(d), 64'h8040_0000);
        end
        repeat (3) @(negedge clk);
        snap(a, pa);
        repeat (17) @(negedge clk);
        snap(b, pb);
        ex  = (pb - w) / per - (pa - w) / per;
        exp = neg ? a + 64'(pb - pa) - 64'(ex) : a + 64'(pb - pa) + 64'(ex);
        chk(req, b, exp);
        wr(4'hC, 32'h0, w);
    endtask

    task automatic t_halt_hold();
        logic [63:0] s1, s2, b, exp; int unsigned p1, p2, pb, w, s, r, e, as, ap;
        wr(4'hC, 32'h8030_0000, w);
        repeat (2) @(negedge clk);
        wr(4'h0, 32'h1, s);
        snap(s1, p1); repeat (6) @(negedge clk); snap(s2, p2);
        chk("R7 count holds while halted", s2, s1);
        wr(4'h0, 32'h2, r);
        repeat (4) @(negedge clk);
        snap(b, pb);
        as  = s - w;
        ap  = as + (pb - r);
        exp = s1 + 64'(pb - r) + 64'(ap / 6 - as / 6);
        chk("R7 accumulator phase held", b, exp);
        wr(4'h0, 32'h3, e);
        snap(s1, p1); repeat (5) @(negedge clk); snap(s2, p2);
        chk("R7 halt wins over release", s2, s1);
        wr(4'h0, 32'h2, r);
        wr(4'hC, 32'h0, w);
    endtask

    task automatic t_load();
        logic [63:0] v; int unsigned p, e, r;
        wr(4'h0, 32'h1, e);
        wr(4'h4, 32'h89AB_CDEF, e);
        wr(4'h8, 32'h0123_4567, e);
        snap(v, p);
        chk("R8 loaded while halted", v, 64'h0123_4567_89AB_CDEF);
        wr(4'h0, 32'h2, r);
        snap(v, p);
        chk("R8 counts on from load", v, 64'h0123_4567_89AB_CDEF + 64'(p - r));
    endtask

    task automatic t_ignore();
        logic [63:0] a, b; int unsigned pa, pb, e;
        snap(a, pa);
        wr(4'h4, 32'hDEAD_BEEF, e);
        wr(4'h8, 32'h0000_0055, e);
        snap(b, pb);
        chk("R9 load ignored while running", b, a + 64'(pb - pa));
    endtask

    task automatic t_shadow();
        logic [63:0] v; logic [31:0] lo, hi; int unsigned p, pl, e, r;
        wr(4'h0, 32'h1, e);
        wr(4'h4, 32'hFFFF_FFFD, e);
        wr(4'h8, 32'h0000_0012, e);
        wr(4'h0, 32'h2, r);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'h4;
        #1 lo = bus_rdata;
        pl = cyc;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R10 low word live", 64'(lo), 64'(32'hFFFF_FFFD + (pl - r)));
        repeat (5) @(negedge clk);
        rdw(4'h8, hi);
        chk("R10 high word from shadow", 64'(hi), 64'h12);
        snap(v, p);
        chk("R10 fresh pair after carry", v, 64'h12_FFFF_FFFD + 64'(p - r));
    endtask

    task automatic t_wrap();
        logic [63:0] v; int unsigned p, e, r;
        wr(4'h0, 32'h1, e);
        wr(4'h4, 32'hFFFF_FFFF, e);
        wr(4'h8, 32'hFFFF_FFFF, e);
        wr(4'h0, 32'h2, r);
        snap(v, p);
        chk("R11 wrap modulo 2^64", v, 64'hFFFF_FFFF_FFFF_FFFF + 64'(p - r));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_nominal();
        t_zero_cfg();
        t_trim(24'h30_0000, 1'b0, "R3 positive trim");
        t_trim(24'h40_0000, 1'b1, "R4 negative trim");
        t_trim(24'hFF_FFFF, 1'b0, "R6 saturated rate");
        t_halt_hold();
        t_load();
        t_ignore();
        t_shadow();
        t_wrap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule